// File: doc/BRIEF.md
# Thread Yield Decision Unit

This block settles what a yield request from a hardware thread context does. The request carries a signed operand and a qualifier mask, together with a snapshot of the calling context and of every context's binding and state bits. The block reaches one of three outcomes: it deactivates the caller, it raises a thread fault with a cause code, or it lets the request through. In every case it returns the operand masked by the qualifier, which later scheduling logic can use as the rescheduling condition.

The sign of the operand selects the path.

- **Zero:** asks for deactivation. The caller's activity bit is cleared only if some context matches the caller's domain and context number, and that context is dynamically allocatable, not halted and currently active.
- **Positive:** asks for a conditional reschedule. It traps when any operand bit lies outside the qualifier mask.
- **Negative:** asks for a plain yield. It traps only when the yield-interrupt enable is set and the caller's context is dirty.
- **Minus two:** reserved as a no-op. It never traps and never touches the caller's state.

The block does not schedule other threads.

Top module: `yield_decider`

## Requirements
- R1: Every response is registered. `rsp_valid` is high in exactly the cycle after the one in which `req_valid` was high. While `rsp_valid` is low, and after reset, `rsp_active`, `rsp_fault`, `rsp_cause` and `rsp_result` are all zero.
- R2: `rsp_result` equals the request operand bitwise-ANDed with `qual_mask`, whatever the operand class.
- R3: For a zero operand, suppose some context entry has the caller's domain and context number, its dynamic bit is 1, its halted bit is 0 and its active bit is 1. Then `rsp_active` is 0, `rsp_fault` is 0 and `rsp_cause` is 0.
- R4: For a zero operand with no such entry (a halted entry, a non-dynamic entry, or no entry matching both domain and number), `rsp_active` equals `caller_active` and no fault is raised.
- R5: For a positive operand (sign bit 0, not zero) with any bit set outside `qual_mask`, `rsp_fault` is 1 and `rsp_cause` is 3'd2.
- R6: For a positive operand whose set bits all lie inside `qual_mask`, there is no fault, the cause is 0 and `rsp_active` equals `caller_active`.
- R7: For a negative operand other than minus two, when `sched_irq_en` and `caller_dirty` are both 1, `rsp_fault` is 1 and `rsp_cause` is 3'd4.
- R8: For a negative operand other than minus two, when either `sched_irq_en` or `caller_dirty` is 0, there is no fault and the cause is 0.
- R9: An operand of exactly minus two gives no fault, a cause of 0, and `rsp_active` equal to `caller_active`, whatever the enable and dirty inputs are.
- R10: Whenever `rsp_fault` is 1, `rsp_active` equals the `caller_active` value of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Yield request strobe |
| req_operand | input | W | Signed yield operand |
| qual_mask | input | W | Yield qualifier mask |
| caller_domain | input | DOM_W | Domain the caller is bound to |
| caller_id | input | ID_W | Caller's context number |
| caller_active | input | 1 | Caller's current activity bit |
| caller_dirty | input | 1 | Caller's dirty-context bit |
| sched_irq_en | input | 1 | Yield-interrupt enable from domain control |
| ctx_domain | input | NCTX*DOM_W | Domain binding of each context, context 0 in the low bits |
| ctx_id | input | NCTX*ID_W | Context number recorded for each entry |
| ctx_dynamic | input | NCTX | Dynamically-allocatable bit of each context |
| ctx_halted | input | NCTX | Halt bit of each context |
| ctx_active | input | NCTX | Activity bit of each context |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_active | output | 1 | New activity bit for the caller |
| rsp_fault | output | 1 | Thread fault raised |
| rsp_cause | output | 3 | Exception cause: 0 none, 2 mask violation, 4 dirty yield |
| rsp_result | output | W | Operand ANDed with the qualifier mask |

## Verification
The bench builds the unit with a 32-bit operand, four contexts and a two-bit domain field. This is enough to place a qualifying entry at both the lowest and the highest context index. It also allows entries that fail the deactivation test in one way each: halted, non-dynamic, and matching the context number but not the domain. The full 32-bit width lets the bench use both the largest positive operand and several negative patterns, including the reserved minus-two value.

// File: rtl/yd_pkg.sv
package yd_pkg;

   localparam int CAUSE_W = 3;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_NONE  = 3'd0,
      CAUSE_MASK  = 3'd2,
      CAUSE_DIRTY = 3'd4
   } yd_cause_e;

   typedef enum logic [1:0] {
      OPC_ZERO    = 2'd0,
      OPC_POS     = 2'd1,
      OPC_RELEASE = 2'd2,
      OPC_NEG     = 2'd3
   } yd_opclass_e;

   typedef struct packed {
      logic      fault;
      yd_cause_e cause;
      logic      active;
   } yd_decision_t;

endpackage

// File: rtl/yd_classify.sv
module yd_classify
   import yd_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] operand,
   input  logic [W-1:0] mask,
   output yd_opclass_e  op_class,
   output logic         mask_viol
);

   localparam logic [W-1:0] MINUS_TWO = {{(W-1){1'b1}}, 1'b0};

   logic is_zero;
   logic is_neg;

   assign is_zero   = (operand == '0);
   assign is_neg    = operand[W-1];
   assign mask_viol = |(operand & ~mask);

   always_comb begin
      if (is_zero)                   op_class = OPC_ZERO;
      else if (!is_neg)              op_class = OPC_POS;
      else if (operand == MINUS_TWO) op_class = OPC_RELEASE;
      else                           op_class = OPC_NEG;
   end

endmodule

// File: rtl/yd_ctx_match.sv
module yd_ctx_match #(
   parameter int NCTX  = 4,
   parameter int DOM_W = 2,
   parameter int ID_W  = 2
) (
   input  logic [DOM_W-1:0]      caller_domain,
   input  logic [ID_W-1:0]       caller_id,
   input  logic [NCTX*DOM_W-1:0] ctx_domain,
   input  logic [NCTX*ID_W-1:0]  ctx_id,
   input  logic [NCTX-1:0]       ctx_dynamic,
   input  logic [NCTX-1:0]       ctx_halted,
   input  logic [NCTX-1:0]       ctx_active,
   output logic                  any_hit
);

   logic [NCTX-1:0] hit;

   for (genvar i = 0; i < NCTX; i++) begin : g_entry
      logic dom_eq;
      logic id_eq;
      assign dom_eq = (ctx_domain[i*DOM_W +: DOM_W] == caller_domain);
      assign id_eq  = (ctx_id[i*ID_W +: ID_W] == caller_id);
      assign hit[i] = dom_eq & id_eq & ctx_dynamic[i] & ~ctx_halted[i] & ctx_active[i];
   end

   assign any_hit = |hit;

endmodule

// File: rtl/yd_decide.sv
module yd_decide
   import yd_pkg::*;
(
   input  yd_opclass_e  op_class,
   input  logic         mask_viol,
   input  logic         any_hit,
   input  logic         sched_irq_en,
   input  logic         caller_dirty,
   input  logic         caller_active,
   output yd_decision_t dec
);

   always_comb begin
      dec.fault  = 1'b0;
      dec.cause  = CAUSE_NONE;
      dec.active = caller_active;
      unique case (op_class)
         OPC_ZERO: begin
            if (any_hit) dec.active = 1'b0;
         end
         OPC_POS: begin
            if (mask_viol) begin
               dec.fault = 1'b1;
               dec.cause = CAUSE_MASK;
            end
         end
         OPC_NEG: begin
            if (sched_irq_en && caller_dirty) begin
               dec.fault = 1'b1;
               dec.cause = CAUSE_DIRTY;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/yield_decider.sv
module yield_decider
   import yd_pkg::*;
#(
   parameter int W     = 32,
   parameter int NCTX  = 4,
   parameter int DOM_W = 2,
   parameter int ID_W  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [W-1:0]          req_operand,
   input  logic [W-1:0]          qual_mask,
   input  logic [DOM_W-1:0]      caller_domain,
   input  logic [ID_W-1:0]       caller_id,
   input  logic                  caller_active,
   input  logic                  caller_dirty,
   input  logic                  sched_irq_en,
   input  logic [NCTX*DOM_W-1:0] ctx_domain,
   input  logic [NCTX*ID_W-1:0]  ctx_id,
   input  logic [NCTX-1:0]       ctx_dynamic,
   input  logic [NCTX-1:0]       ctx_halted,
   input  logic [NCTX-1:0]       ctx_active,
   output logic                  rsp_valid,
   output logic                  rsp_active,
   output logic                  rsp_fault,
   output logic [CAUSE_W-1:0]    rsp_cause,
   output logic [W-1:0]          rsp_result
);

   // Elaboration-time parameter checks
   if (W < 4) begin : g_bad_w
      $error("yield_decider: W must be at least 4");
   end
   if (NCTX < 1) begin : g_bad_nctx
      $error("yield_decider: NCTX must be at least 1");
   end
   if (DOM_W < 1) begin : g_bad_dom
      $error("yield_decider: DOM_W must be at least 1");
   end
   if ((1 << ID_W) < NCTX) begin : g_bad_id
      $error("yield_decider: ID_W too narrow for NCTX");
   end

   yd_opclass_e  op_class;
   logic         mask_viol;
   logic         any_hit;
   yd_decision_t dec;

   yd_classify #(.W(W)) u_class (
      .operand   (req_operand),
      .mask      (qual_mask),
      .op_class  (op_class),
      .mask_viol (mask_viol)
   );

   yd_ctx_match #(.NCTX(NCTX), .DOM_W(DOM_W), .ID_W(ID_W)) u_match (
      .caller_domain (caller_domain),
      .caller_id     (caller_id),
      .ctx_domain    (ctx_domain),
      .ctx_id        (ctx_id),
      .ctx_dynamic   (ctx_dynamic),
      .ctx_halted    (ctx_halted),
      .ctx_active    (ctx_active),
      .any_hit       (any_hit)
   );

   yd_decide u_decide (
      .op_class      (op_class),
      .mask_viol     (mask_viol),
      .any_hit       (any_hit),
      .sched_irq_en  (sched_irq_en),
      .caller_dirty  (caller_dirty),
      .caller_active (caller_active),
      .dec           (dec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_active <= 1'b0;
         rsp_fault  <= 1'b0;
         rsp_cause  <= '0;
         rsp_result <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_active <= dec.active;
            rsp_fault  <= dec.fault;
            rsp_cause  <= dec.cause;
            rsp_result <= req_operand & qual_mask;
         end else begin
            rsp_active <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_cause  <= '0;
            rsp_result <= '0;
         end
      end
   end

endmodule

// File: rtl/yd_checker.sv
module yd_checker #(
   parameter int W     = 32,
   parameter int NCTX  = 4,
   parameter int DOM_W = 2,
   parameter int ID_W  = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic [W-1:0]          req_operand,
   input logic [W-1:0]          qual_mask,
   input logic                  caller_active,
   input logic                  caller_dirty,
   input logic                  sched_irq_en,
   input logic                  rsp_valid,
   input logic                  rsp_active,
   input logic                  rsp_fault,
   input logic [2:0]            rsp_cause,
   input logic [W-1:0]          rsp_result
);

   localparam logic [W-1:0] NEG_TWO = {{(W-1){1'b1}}, 1'b0};

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid));

   a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_fault && !rsp_active && rsp_cause == 3'd0 && rsp_result == '0));

   a_r2_result: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_result == $past(req_operand & qual_mask));

   a_r5_mask_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(req_operand[W-1]) && $past(|(req_operand & ~qual_mask)))
         |-> (rsp_fault && rsp_cause == 3'd2));

   a_r7_dirty_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_operand[W-1]) && $past(req_operand) != NEG_TWO
         && $past(sched_irq_en && caller_dirty)) |-> (rsp_fault && rsp_cause == 3'd4));

   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_operand) == NEG_TWO)
         |-> (!rsp_fault && rsp_active == $past(caller_active)));

   a_r10_keep_active: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_active == $past(caller_active));

   a_r5_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_cause == 3'd2 || rsp_cause == 3'd4));

endmodule

bind yield_decider yd_checker #(.W(W), .NCTX(NCTX), .DOM_W(DOM_W), .ID_W(ID_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_operand   (req_operand),
   .qual_mask     (qual_mask),
   .caller_active (caller_active),
   .caller_dirty  (caller_dirty),
   .sched_irq_en  (sched_irq_en),
   .rsp_valid     (rsp_valid),
   .rsp_active    (rsp_active),
   .rsp_fault     (rsp_fault),
   .rsp_cause     (rsp_cause),
   .rsp_result    (rsp_result)
);

// File: tb/yield_decider_test.sv
`timescale 1ns/1ps
module yield_decider_test;

   localparam int W = 32, NCTX = 4, DOM_W = 2, ID_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [W-1:0] req_operand = '0, qual_mask = '0;
   logic [DOM_W-1:0] caller_domain = '0;
   logic [ID_W-1:0] caller_id = '0;
   logic caller_active = 1'b0, caller_dirty = 1'b0, sched_irq_en = 1'b0;
   // ctx3..ctx0: dom 1,1,0,0 ; id 3,2,1,0 ; ctx2 not dynamic ; ctx1 halted
   logic [NCTX*DOM_W-1:0] ctx_domain = {2'd1, 2'd1, 2'd0, 2'd0};
   logic [NCTX*ID_W-1:0]  ctx_id     = {2'd3, 2'd2, 2'd1, 2'd0};
   logic [NCTX-1:0] ctx_dynamic = 4'b1011;
   logic [NCTX-1:0] ctx_halted  = 4'b0010;
   logic [NCTX-1:0] ctx_active  = 4'b1111;
   logic rsp_valid, rsp_active, rsp_fault;
   logic [2:0] rsp_cause;
   logic [W-1:0] rsp_result;

   int n_checks = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   yield_decider #(.W(W), .NCTX(NCTX), .DOM_W(DOM_W), .ID_W(ID_W)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_operand(req_operand),
      .qual_mask(qual_mask), .caller_domain(caller_domain), .caller_id(caller_id),
      .caller_active(caller_active), .caller_dirty(caller_dirty),
      .sched_irq_en(sched_irq_en), .ctx_domain(ctx_domain), .ctx_id(ctx_id),
      .ctx_dynamic(ctx_dynamic), .ctx_halted(ctx_halted), .ctx_active(ctx_active),
      .rsp_valid(rsp_valid), .rsp_active(rsp_active), .rsp_fault(rsp_fault),
      .rsp_cause(rsp_cause), .rsp_result(rsp_result));

   typedef struct packed {
      logic [31:0] op;
      logic [31:0] mask;
      logic [1:0]  dom;
      logic [1:0]  id;
      logic        act;
      logic        dirty;
      logic        sie;
      logic        efault;
      logic [2:0]  ecause;
      logic        eact;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{32'h0, 32'hFF, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R3 hit ctx0
      '{32'h0, 32'hFF, 2'd1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0}, // R3 hit ctx3
      '{32'h0, 32'hFF, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R4 halted
      '{32'h0, 32'hFF, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R4 not dynamic
      '{32'h0, 32'hFF, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R4 domain mismatch
      '{32'h10, 32'h0F, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1}, // R5 R10
      '{32'h7FFF0000, 32'h0000FFFF, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 1'b0}, // R5
      '{32'h0C, 32'h0F, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b1}, // R6
      '{32'h7FFFFFFF, 32'h7FFFFFFF, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R6
      '{32'hFFFFFFFF, 32'hF0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd4, 1'b1}, // R7 R10
      '{32'hFFFFFFFD, 32'hFF, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd4, 1'b0}, // R7 R10
      '{32'hFFFFFFFF, 32'hF0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1}, // R8 enable low
      '{32'hFFFFFFFB, 32'hFFFF, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1}, // R8 clean
      '{32'hFFFFFFFE, 32'h0F0F, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b1}  // R9
   };

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_idle(input string tag);
      check({tag, " valid"},  W'(rsp_valid), '0);
      check({tag, " fault"},  W'(rsp_fault), '0);
      check({tag, " active"}, W'(rsp_active), '0);
      check({tag, " cause"},  W'(rsp_cause), '0);
      check({tag, " result"}, rsp_result, '0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after reset");

      // Table walk: each vector is one request, response sampled a cycle later
      for (int v = 0; v < NV; v++) begin
         req_operand   = VECS[v].op;
         qual_mask     = VECS[v].mask;
         caller_domain = VECS[v].dom;
         caller_id     = VECS[v].id;
         caller_active = VECS[v].act;
         caller_dirty  = VECS[v].dirty;
         sched_irq_en  = VECS[v].sie;
         req_valid     = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         check($sformatf("R1 vec%0d valid", v), W'(rsp_valid), W'(1));
         check($sformatf("R5/R7 vec%0d fault", v), W'(rsp_fault), W'(VECS[v].efault));
         check($sformatf("R5/R7 vec%0d cause", v), W'(rsp_cause), W'(VECS[v].ecause));
         check($sformatf("R3/R4/R10 vec%0d active", v), W'(rsp_active), W'(VECS[v].eact));
         check($sformatf("R2 vec%0d result", v), rsp_result, VECS[v].op & VECS[v].mask);
      end

      // R1: response drops to zero once the request goes away
      @(negedge clk);
      check_idle("R1 idle");

      // R9: minus two with caller inactive, enable and dirty set
      req_operand = 32'hFFFFFFFE; qual_mask = 32'hFFFFFFFF;
      caller_active = 1'b0; caller_dirty = 1'b1; sched_irq_en = 1'b1;
      req_valid = 1'b1;
      @(negedge clk);
      check("R9 fault", W'(rsp_fault), '0);
      check("R9 active", W'(rsp_active), '0);
      check("R2 result full mask", rsp_result, 32'hFFFFFFFE);

      // Back-to-back: positive mask trap then zero with a hit (R5, R3)
      req_operand = 32'h00000100; qual_mask = 32'h000000FF; caller_active = 1'b1;
      @(negedge clk);
      check("R5 back-to-back cause", W'(rsp_cause), W'(3'd2));
      check("R10 back-to-back active", W'(rsp_active), W'(1));
      req_operand = '0; caller_domain = 2'd1; caller_id = 2'd3;
      @(negedge clk);
      req_valid = 1'b0;
      check("R3 back-to-back active", W'(rsp_active), '0);
      check("R3 back-to-back fault", W'(rsp_fault), '0);

      // R4: making ctx3 inactive removes the hit
      ctx_active = 4'b0111;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R4 inactive entry", W'(rsp_active), W'(1));

      // R1: reset mid-stream clears outputs
      req_valid = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      check_idle("R1 reset again");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule